// File: doc/BRIEF.md
# Seconds Prescaler with Test Clock Source

This block divides a slow timebase by 64 and emits a one-cycle strobe each time a full second has passed, for use by the seconds counter of a real-time clock. It runs in a fast system clock domain. Two raw, asynchronous tick sources arrive at its edge: the internal 64 Hz tick and an external test pin. Each passes through a synchronizer and a rising-edge detector, and a mode input selects which one steps the prescaler.

A stop input clears the prescaler and holds it at zero. When stop is released, the prescaler restarts from half its range, so the first strobe arrives after 32 source edges and every later strobe after 64. Switching the source does not align the prescaler with the new source. Software that needs a known phase after a mode change pulses stop. The prescaler value is available as an output for observation.

Top module: `rtc_sec_prescaler`

## Requirements
- R1: While rst_ni is low and in the first cycle after it, presc_o is 0 and sec_inc_o is 0.
- R2: With test_mode_i = 0, each rising edge on tick_int_i advances presc_o by exactly one, modulo 64. Edges on tick_ext_i have no effect.
- R3: With test_mode_i = 1, each rising edge on tick_ext_i advances presc_o by exactly one, modulo 64. Edges on tick_int_i have no effect.
- R4: sec_inc_o is high for exactly one system clock cycle, and only in the cycle in which presc_o has wrapped from 63 to 0.
- R5: While stop_i = 1, presc_o is 0, source edges are ignored and sec_inc_o stays low.
- R6: In the first cycle after stop_i returns to 0, presc_o becomes 32. The first sec_inc_o then follows the 32nd selected edge, and each later one follows every 64 further edges.
- R7: A rising edge on the selected raw input changes presc_o on the third system clock edge after it is sampled high, and not earlier.
- R8: A source input held high for many cycles produces one step only. Falling edges produce no step.
- R9: Changing test_mode_i while both raw inputs are static does not change presc_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, fast enough to sample every test-pin level |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_int_i | input | 1 | Raw internal 64 Hz tick, asynchronous |
| tick_ext_i | input | 1 | Raw external test tick, asynchronous |
| test_mode_i | input | 1 | 1 selects tick_ext_i as the prescaler source |
| stop_i | input | 1 | 1 clears and holds the prescaler |
| sec_inc_o | output | 1 | One-cycle seconds increment strobe |
| presc_o | output | 6 | Current prescaler value |

## Verification
The bench drives random sequences of pulses on both sources, mode flips and stop pulses. It compares presc_o and the strobe count after each action with a model, which shows whether the wrong source steps the counter or an edge is lost or doubled. Directed cases cover the release sequence of 32 and then 64 edges, to distinguish a reload at 32 from a reload at zero. A long-held high level separates edge detection from level sensing. A cycle-exact probe after a single rising edge checks the synchronizer depth.

// File: rtl/rtc_presc_pkg.sv
package rtc_presc_pkg;
  localparam int unsigned PRESC_W_DEF = 6;
  localparam int unsigned SYNC_DEF    = 2;
  localparam int unsigned N_SRC       = 2;
  typedef enum logic {SRC_INT = 1'b0, SRC_EXT = 1'b1} src_e;
endpackage

// File: rtl/rtc_tick_sync.sv
module rtc_tick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], raw_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R8
endmodule

// File: rtl/rtc_presc_core.sv
module rtc_presc_core #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         stop_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] MAX_V  = {W{1'b1}};
  localparam logic [W-1:0] HALF_V = W'(1) << (W - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         held_q, held_d, wrap_q, wrap_d;

  always_comb begin
    cnt_d  = cnt_q;
    held_d = held_q;
    wrap_d = 1'b0;
    if (stop_i) begin
      cnt_d  = '0;
      held_d = 1'b1;
    end else if (held_q) begin
      // restart at half range so the first strobe comes after half a period
      cnt_d  = HALF_V + W'(step_i);
      held_d = 1'b0;
    end else if (step_i) begin
      cnt_d  = cnt_q + W'(1);
      wrap_d = (cnt_q == MAX_V);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      held_q <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      held_q <= held_d;
      wrap_q <= wrap_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;

  AST_STOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (cnt_o == '0) && !wrap_o); // R5
  AST_RELEASE_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_i && held_q) |=> cnt_o == HALF_V + W'($past(step_i))); // R6
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !stop_i && !held_q) |=> cnt_o == $past(cnt_o) + W'(1)); // R2
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !stop_i && !held_q) |=> $stable(cnt_o)); // R8
endmodule

// File: rtl/rtc_sec_prescaler.sv
module rtc_sec_prescaler
  import rtc_presc_pkg::*;
#(
  parameter int unsigned PRESC_W     = PRESC_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_int_i,
  input  logic               tick_ext_i,
  input  logic               test_mode_i,
  input  logic               stop_i,
  output logic               sec_inc_o,
  output logic [PRESC_W-1:0] presc_o
);
  logic [N_SRC-1:0] raw, rise;
  logic             step;
  src_e             sel;

  assign raw = {tick_ext_i, tick_int_i};

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    rtc_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw[g]),
      .rise_o (rise[g])
    );
  end

  // source switch is not aligned: both paths are edge-detected independently
  assign sel  = test_mode_i ? SRC_EXT : SRC_INT;
  assign step = rise[sel];

  rtc_presc_core #(.W(PRESC_W)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .stop_i (stop_i),
    .cnt_o  (presc_o),
    .wrap_o (sec_inc_o)
  );

  AST_INC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_inc_o |=> !sec_inc_o); // R4
  AST_INC_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_inc_o |-> (presc_o == '0) && ($past(presc_o) == {PRESC_W{1'b1}})); // R4
  AST_SRC_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise[sel] && !stop_i && (presc_o != '0)) |=> (presc_o == $past(presc_o)) || (presc_o == {1'b1, {(PRESC_W-1){1'b0}}})); // R9
endmodule

// File: tb/rtc_sec_prescaler_test.sv
module rtc_sec_prescaler_test;
  logic clk = 0, rst_ni = 0;
  logic tick_int = 0, tick_ext = 0, mode = 0, stop = 0;
  logic sec_inc;
  logic [5:0] presc;

  int checks = 0, errors = 0, strobes = 0;
  int m_cnt = 0, m_str = 0;
  bit m_mode = 0, done = 0;

  always #2 clk = ~clk;

  rtc_sec_prescaler uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_int_i(tick_int), .tick_ext_i(tick_ext),
    .test_mode_i(mode), .stop_i(stop), .sec_inc_o(sec_inc), .presc_o(presc)
  );

  always @(negedge clk) if (rst_ni && sec_inc) strobes++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int step_model(input int c);
    return (c + 1) % 64;
  endfunction

  // one pulse on a source: high 3, low 3, settle 2
  task automatic pulse(input bit ext);
    if (ext) tick_ext = 1; else tick_int = 1;
    cyc(3);
    if (ext) tick_ext = 0; else tick_int = 0;
    cyc(5);
    if (ext == m_mode) begin
      if (m_cnt == 63) m_str++;
      m_cnt = step_model(m_cnt);
    end
  endtask

  task automatic do_stop(input bit with_edges);
    stop = 1;
    cyc(2);
    chk("R5 held zero", presc, 0);
    if (with_edges) begin
      pulse(m_mode); m_cnt = 0;
      pulse(!m_mode); m_cnt = 0;
      chk("R5 edges ignored", presc, 0);
      chk("R5 no strobe", strobes, m_str);
    end
    @(negedge clk); stop = 0;
    cyc(2);
    m_cnt = 32;
    chk("R6 reload half", presc, 32);
  endtask

  initial begin
    cyc(3);
    chk("R1 reset presc", presc, 0);
    chk("R1 reset strobe", sec_inc, 0);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 after reset", presc, 0);
    cyc(2);

    // R7 latency probe
    tick_int = 1;
    cyc(2);
    chk("R7 no early step", presc, 0);
    cyc(1);
    chk("R7 step at third edge", presc, 1);
    // R8 long high level: one step only
    cyc(40);
    tick_int = 0;
    cyc(10);
    chk("R8 level gives one step", presc, 1);
    m_cnt = 1;

    // R2 normal mode, ext ignored
    pulse(1);
    chk("R2 ext ignored", presc, m_cnt);
    pulse(0);
    chk("R2 int steps", presc, m_cnt);

    // R3 test mode
    mode = 1; m_mode = 1; cyc(3);
    chk("R9 switch no step", presc, m_cnt);
    pulse(0);
    chk("R3 int ignored", presc, m_cnt);
    pulse(1);
    chk("R3 ext steps", presc, m_cnt);

    // R6 first strobe after 32, then 64
    do_stop(1);
    for (int i = 0; i < 31; i++) pulse(1);
    chk("R6 no strobe before 32", strobes, m_str);
    pulse(1);
    chk("R6 strobe at 32nd edge", strobes, m_str);
    chk("R4 wrapped to zero", presc, 0);
    for (int i = 0; i < 63; i++) pulse(1);
    chk("R6 no strobe before 64", strobes, m_str);
    pulse(1);
    chk("R6 strobe after 64", strobes, m_str);

    // random mix
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 19);
      if (op < 8) pulse(0);
      else if (op < 16) pulse(1);
      else if (op < 18) begin
        mode = ~mode; m_mode = mode; cyc(3);
        chk("R9 random switch", presc, m_cnt);
      end else do_stop(op[0]);
      chk("R2 R3 random presc", presc, m_cnt);
      chk("R4 random strobes", strobes, m_str);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule